// File: doc/BRIEF.md
# Sticky Fault Latch with Serial Readout

This block gathers the fault state of four low-side driver channels and reports it to a host over a four-wire serial slave port. Each channel supplies three classification bits. A per-channel decoder turns them into a short-circuit flag and an open-load flag. Every flag is latched in a sticky register that is kept apart from the serial shift register. A fault that is detected while a transfer is running therefore neither disturbs the word being shifted nor gets lost.

When chip select goes low, the eight flags are packed into one byte and loaded into the shift register. The byte leaves on the data output MSB first. The outgoing bit changes on the falling serial clock, and the host samples it on the rising edge. Data arriving on the serial input is shifted in behind the word, so a longer frame returns the received bits, as in a daisy chain. A frame with exactly eight rising clocks, closed by chip select going high, clears exactly those latched flags that were captured into the byte. All serial pins and fault inputs are sampled in the system clock domain.

Top module: `fault_latch_spi`

## Requirements
- R1: For each channel with classification bits X,Y,Z (X the MSB), the short-circuit flag is 1 for XYZ = 010, 100, 101, 110, 111 and 0 for 000, 001, 011.
- R2: The open-load flag is 1 only for XYZ = 011, so the two flags of a channel are never both 1.
- R3: A latched flag stays set after its fault disappears, until a completed read clears it.
- R4: The byte is ordered bit 7 to bit 0 as ch0 short, ch0 open, ch1 short, ch1 open, ch2 short, ch2 open, ch3 short, ch3 open (ch0..ch3 = drivers 1A, 4A, 1B, 4B), and bit 7 is shifted out first.
- R5: The byte is loaded when chip select falls. The output enable is high only while a frame is selected, and the data output reads 0 whenever the enable is low.
- R6: The data output changes only after a falling serial clock and holds while the serial clock is high.
- R7: A frame with exactly 8 rising serial clocks clears the latched flags that were captured, once chip select rises.
- R8: A frame with any other number of rising clocks leaves the latched flags unchanged.
- R9: A fault latched after the byte was loaded survives the clear and is reported by the next read.
- R10: A fault still present when the clear takes effect is latched again and reported by the next read.
- R11: Serial input bits are sampled on rising clocks and shifted in at the LSB, so rising clocks 9 to 16 return the first eight input bits in order.
- R12: After reset the flags are clear, the output enable is low and a first read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_x_i | input | NUM_CH | Classification bit X per channel (MSB) |
| mem_y_i | input | NUM_CH | Classification bit Y per channel |
| mem_z_i | input | NUM_CH | Classification bit Z per channel (LSB) |
| spi_clk_i | input | 1 | Serial clock from host, idle low |
| spi_sdi_i | input | 1 | Serial data from host |
| spi_ncs_i | input | 1 | Active-low chip select |
| spi_sdo_o | output | 1 | Serial data to host |
| spi_sdo_en_o | output | 1 | Drive enable for the data output; the pin is released when low |

## Verification
The assertions assume that every serial clock phase and every chip select level lasts several system clocks, so each edge is seen once after synchronisation. They also assume the classification bits stay stable long enough to pass the synchroniser. The bench holds each serial half period for eight system clocks. It changes fault inputs at least six clocks before any point where they must be latched, and it keeps the serial clock low whenever chip select changes. Under these limits the edge detectors never merge or miss an edge.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  localparam int unsigned FLAGS_PER_CH = 2;

  function automatic logic is_short(input logic x, input logic y, input logic z);
    return x | (y & ~z);
  endfunction

  function automatic logic is_open(input logic x, input logic y, input logic z);
    return ~x & y & z;
  endfunction
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= {W{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fault_decode.sv
module fault_decode #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] x_i,
  input  logic [NUM_CH-1:0] y_i,
  input  logic [NUM_CH-1:0] z_i,
  output logic [NUM_CH-1:0] sc_o,
  output logic [NUM_CH-1:0] ol_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sc_o[c] = fault_latch_pkg::is_short(x_i[c], y_i[c], z_i[c]);
    assign ol_o[c] = fault_latch_pkg::is_open(x_i[c], y_i[c], z_i[c]);
  end
endmodule

// File: rtl/fault_store.sv
module fault_store #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned WORD_W = NUM_CH * fault_latch_pkg::FLAGS_PER_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] sc_i,
  input  logic [NUM_CH-1:0] ol_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] clr_mask_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] set_vec, sticky_q, keep_vec;

  // channel 0 lands in the top pair
  for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
    assign set_vec[WORD_W-1-2*c] = sc_i[c];
    assign set_vec[WORD_W-2-2*c] = ol_i[c];
  end

  assign keep_vec = clr_i ? ~clr_mask_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & keep_vec) | set_vec;
  end

  assign word_o = sticky_q;
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              ncs_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              shift_o,
  output logic              clr_o,
  output logic [WORD_W-1:0] mask_o
);
  logic              sclk_q, ncs_q, en_q, sdi_q;
  logic [WORD_W-1:0] shreg_q, mask_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ncs_fall, ncs_rise, sclk_rise, sclk_fall;

  assign ncs_fall  = ncs_q & ~ncs_i;
  assign ncs_rise  = ~ncs_q & ncs_i;
  assign sclk_rise = en_q & ~ncs_i & ~sclk_q & sclk_i;
  assign sclk_fall = en_q & ~ncs_i & sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      ncs_q   <= 1'b1;
      en_q    <= 1'b0;
      sdi_q   <= 1'b0;
      shreg_q <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      ncs_q  <= ncs_i;
      if (ncs_fall) begin
        shreg_q <= load_word_i;
        mask_q  <= load_word_i;
        cnt_q   <= '0;
        en_q    <= 1'b1;
      end else begin
        if (sclk_rise) begin
          sdi_q <= sdi_i;
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall) shreg_q <= {shreg_q[WORD_W-2:0], sdi_q};
        if (ncs_rise)  en_q <= 1'b0;
      end
    end
  end

  assign clr_o    = ncs_rise & en_q & (cnt_q == CNT_W'(WORD_W));
  assign sdo_en_o = en_q;
  assign sdo_o    = en_q & shreg_q[WORD_W-1];
  assign shift_o  = sclk_fall;
  assign mask_o   = mask_q;
endmodule

// File: rtl/fault_latch_spi.sv
module fault_latch_spi #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] mem_x_i,
  input  logic [NUM_CH-1:0] mem_y_i,
  input  logic [NUM_CH-1:0] mem_z_i,
  input  logic              spi_clk_i,
  input  logic              spi_sdi_i,
  input  logic              spi_ncs_i,
  output logic              spi_sdo_o,
  output logic              spi_sdo_en_o
);
  localparam int unsigned WORD_W = NUM_CH * fault_latch_pkg::FLAGS_PER_CH;
  localparam int unsigned MEM_W  = 3 * NUM_CH;

  logic [MEM_W-1:0]  mem_s;
  logic [1:0]        lo_s;
  logic              ncs_s;
  logic [NUM_CH-1:0] sc_w, ol_w;
  logic [WORD_W-1:0] sticky_w, mask_w;
  logic              clr_w, shift_w;

  fault_sync #(.W(MEM_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mem (
    .clk_i, .rst_ni, .d_i({mem_x_i, mem_y_i, mem_z_i}), .q_o(mem_s)
  );
  fault_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lo (
    .clk_i, .rst_ni, .d_i({spi_clk_i, spi_sdi_i}), .q_o(lo_s)
  );
  // chip select idles high through reset
  fault_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(spi_ncs_i), .q_o(ncs_s)
  );

  fault_decode #(.NUM_CH(NUM_CH)) u_dec (
    .x_i(mem_s[3*NUM_CH-1:2*NUM_CH]),
    .y_i(mem_s[2*NUM_CH-1:NUM_CH]),
    .z_i(mem_s[NUM_CH-1:0]),
    .sc_o(sc_w),
    .ol_o(ol_w)
  );

  fault_store #(.NUM_CH(NUM_CH)) u_store (
    .clk_i, .rst_ni, .sc_i(sc_w), .ol_i(ol_w),
    .clr_i(clr_w), .clr_mask_i(mask_w), .word_o(sticky_w)
  );

  spi_shift #(.WORD_W(WORD_W)) u_spi (
    .clk_i, .rst_ni,
    .sclk_i(lo_s[1]), .ncs_i(ncs_s), .sdi_i(lo_s[0]),
    .load_word_i(sticky_w),
    .sdo_o(spi_sdo_o), .sdo_en_o(spi_sdo_en_o),
    .shift_o(shift_w), .clr_o(clr_w), .mask_o(mask_w)
  );
endmodule

// File: rtl/fault_latch_chk.sv
module fault_latch_chk #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned WORD_W = 2 * NUM_CH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_sdo_o,
  input logic              spi_sdo_en_o,
  input logic [NUM_CH-1:0] sc,
  input logic [NUM_CH-1:0] ol,
  input logic [WORD_W-1:0] sticky,
  input logic [WORD_W-1:0] mask,
  input logic              clr,
  input logic              shift
);
  assert_flags_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc & ol) == '0);

  assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |=> ((sticky & $past(sticky)) == $past(sticky)));

  assert_sdo_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sdo_en_o && $past(spi_sdo_en_o) && !$past(shift)) |-> $stable(spi_sdo_o));

  assert_clear_ends_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !spi_sdo_en_o);

  assert_uncaptured_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> ((sticky & $past(sticky) & ~$past(mask)) == ($past(sticky) & ~$past(mask))));
endmodule

bind fault_latch_spi fault_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .spi_sdo_o(spi_sdo_o), .spi_sdo_en_o(spi_sdo_en_o),
  .sc(sc_w), .ol(ol_w), .sticky(sticky_w), .mask(mask_w),
  .clr(clr_w), .shift(shift_w)
);

// File: tb/sim_fault_latch_spi.sv
module sim_fault_latch_spi;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mx = '0, my = '0, mz = '0;
  logic sclk = 1'b0, sdi = 1'b0, ncs = 1'b1;
  logic sdo, sdo_en;
  int total = 0, bad = 0;
  bit done = 0;
  bit [7:0] exp_q = '0;
  bit [15:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_latch_spi u0 (
    .clk_i(clk), .rst_ni(rst_n), .mem_x_i(mx), .mem_y_i(my), .mem_z_i(mz),
    .spi_clk_i(sclk), .spi_sdi_i(sdi), .spi_ncs_i(ncs),
    .spi_sdo_o(sdo), .spi_sdo_en_o(sdo_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // flags from the classification table
  function automatic bit [1:0] classify(input bit [2:0] xyz);
    case (xyz)
      3'b010, 3'b100, 3'b101, 3'b110, 3'b111: return 2'b10;
      3'b011:                                 return 2'b01;
      default:                                return 2'b00;
    endcase
  endfunction

  function automatic bit [7:0] cur_word();
    bit [7:0] w = '0;
    for (int c = 0; c < 4; c++) begin
      bit [1:0] f = classify({mx[c], my[c], mz[c]});
      w[7-2*c] = f[1];
      w[6-2*c] = f[0];
    end
    return w;
  endfunction

  task automatic set_ch(input int c, input bit [2:0] xyz, input bit latch);
    @(negedge clk);
    mx[c] = xyz[2]; my[c] = xyz[1]; mz[c] = xyz[0];
    if (latch) exp_q |= cur_word();
    repeat (6) @(negedge clk);
  endtask

  // read frame; optional fault injected at bit 2 and withdrawn at bit 5
  task automatic xfer(input int nclk, input bit [15:0] din, input int mid_ch,
                      input bit [2:0] mid_xyz, output bit [15:0] dout);
    bit [7:0] cap;
    dout = '0;
    @(negedge clk);
    ncs = 1'b0;
    cap = exp_q;
    repeat (HALF) @(negedge clk);
    chk(sdo_en === 1'b1, "R5 enable in frame", sdo_en, 1);
    for (int i = 0; i < nclk; i++) begin
      if (mid_ch >= 0 && i == 2) begin
        mx[mid_ch] = mid_xyz[2]; my[mid_ch] = mid_xyz[1]; mz[mid_ch] = mid_xyz[0];
        exp_q |= cur_word();
      end
      if (mid_ch >= 0 && i == 5) begin
        mx[mid_ch] = 1'b0; my[mid_ch] = 1'b0; mz[mid_ch] = 1'b0;
      end
      sdi = din[15-i];
      repeat (HALF) @(negedge clk);
      dout[15-i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(sdo === dout[15-i], "R6 steady while high", sdo, dout[15-i]);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ncs = 1'b1;
    repeat (HALF) @(negedge clk);
    chk(sdo_en === 1'b0, "R5 enable after frame", sdo_en, 0);
    if (nclk == 8) exp_q = (exp_q & ~cap) | cur_word();
  endtask

  task automatic read8(input string req, input bit [7:0] expv);
    xfer(8, '0, -1, 3'b000, got);
    chk(got[15:8] == expv, req, got[15:8], expv);
  endtask

  // disabled output must read 0 on every clock
  always @(negedge clk) begin
    if (rst_n && !done) chk(sdo_en || !sdo, "R5 idle data low", sdo, 0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sdo_en === 1'b0 && sdo === 1'b0, "R12 reset outputs", {sdo_en, sdo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read8("R12 first read empty", 8'h00);

    // R1 R2 R10: table sweep on channel 1, fault held across first clear
    for (int v = 0; v < 8; v++) begin
      bit [7:0] w;
      set_ch(1, 3'(v), 1);
      w = {2'b00, classify(3'(v)), 4'b0000};
      read8((v == 3) ? "R2 open-load decode" : "R1 short decode", w);
      chk(exp_q == w, "R10 model persistent", exp_q, w);
      set_ch(1, 3'b000, 0);
      read8("R10 persistent fault reported again", w);
      read8("R7 cleared after read", 8'h00);
    end

    // R4 R3: bit order with faults that went away before the read
    set_ch(0, 3'b100, 1);
    set_ch(2, 3'b010, 1);
    set_ch(3, 3'b011, 1);
    set_ch(0, 3'b000, 0);
    set_ch(2, 3'b000, 0);
    set_ch(3, 3'b000, 0);
    read8("R4 bit order / R3 held", 8'h89);
    read8("R7 clear after exact frame", 8'h00);

    // R8: short and long frames do not clear
    set_ch(0, 3'b110, 1);
    set_ch(0, 3'b000, 0);
    xfer(5, '0, -1, 3'b000, got);
    chk(got[15:11] == 5'b10000, "R8 partial frame bits", got[15:11], 5'b10000);
    xfer(9, '0, -1, 3'b000, got);
    chk(got[15:8] == 8'h80, "R8 long frame data", got[15:8], 8'h80);
    read8("R8 flag kept after odd frames", 8'h80);
    read8("R7 cleared", 8'h00);

    // R9: fault arriving mid-frame survives the clear
    set_ch(1, 3'b101, 1);
    set_ch(1, 3'b000, 0);
    xfer(8, '0, 3, 3'b011, got);
    chk(got[15:8] == 8'h20, "R9 frame holds load-time word", got[15:8], 8'h20);
    read8("R9 late fault reported", 8'h01);
    read8("R9 cleared afterwards", 8'h00);

    // R11: input bits return after the word
    xfer(16, 16'hA500, -1, 3'b000, got);
    chk(got == 16'h00A5, "R11 shifted input returned", got, 16'h00A5);
    chk(exp_q == 8'h00, "R11 model empty", exp_q, 0);
    read8("R11 state after long frame", 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule